// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external SPI master read and write a 128-entry, 8-bit register file. It uses SPI mode 0: SCK idles low, MOSI is sampled on the rising edge, MISO changes on the falling edge, and bytes travel MSB first. Each transaction opens when chip-select goes low. The first byte is a command (0x03 read, 0x02 write). The second byte is a start address. All further bytes are data. After each complete data byte the internal address steps up by one and wraps from 127 to 0, so a single command can sweep the whole register set.

SCK, chip-select and MOSI are brought into the system clock through synchronizer flops, and every edge is detected in that domain. The register file therefore lives entirely on the system clock. Two control fields are decoded from the register file and driven as plain output pins: a switch-enable bit and a two-bit interface speed code. The pins carry no valid/ready handshake. The SPI master cannot be stalled, so the block offers no back-pressure, and it must keep pace with every byte the master clocks.

Top module: `spi_reg_slave`

## Requirements
- R1: Bits are shifted MSB first. MOSI is taken on each rising SCK edge, and MISO holds its value while SCK is high, changing only after a falling edge.
- R2: Command 0x03 followed by an address returns register contents on MISO for each further byte. Each byte's MSB is already driven before that byte's first rising SCK edge.
- R3: Command 0x02 followed by an address stores each further complete byte into the register at the current address.
- R4: Only bits [6:0] of the address byte select the register; bit 7 is ignored.
- R5: While chip-select stays low, the address rises by one after every complete data byte and wraps from 127 to 0, for reads and writes alike.
- R6: Raising chip-select ends the transaction. The first byte after chip-select falls again is decoded as a new command.
- R7: A data byte cut short by chip-select rising is discarded and changes no register.
- R8: Any command byte other than 0x03 or 0x02 makes the rest of the transaction inert. No register changes, and MISO stays low until chip-select rises.
- R9: `sw_enable` equals bit 0 of register 1.
- R10: `spi_speed` equals bits [5:4] of register 12 (00 after reset).
- R11: After reset, every register reads 0 and `miso`, `sw_enable` and `spi_speed` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| sck | input | 1 | SPI serial clock from the master, idle low |
| cs_n | input | 1 | Active-low chip-select from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, low outside read data |
| sw_enable | output | 1 | Switch-enable control, register 1 bit 0 |
| spi_speed | output | 2 | Interface speed code, register 12 bits [5:4] |

## Verification
The checks rest on three assumptions about the inputs. Each SCK phase must last several system clocks longer than the synchronizer delay. MOSI must change only while SCK is low. SCK must be low whenever chip-select moves. The bench honours all three by holding each SCK phase for eight system clocks, updating MOSI straight after a falling edge, and waiting eight clocks on both sides of every chip-select change. Under those conditions the properties can tie the internal write strobe, the address counter and the transaction state together: a write steps the address, chip-select high forces the command state, and MISO stays quiet outside a read.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_WRITE = 8'h02;
  localparam int ENA_REG   = 1;
  localparam int ENA_BIT   = 0;
  localparam int SPEED_REG = 12;
  localparam int SPEED_LSB = 4;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_RD,
    ST_WR,
    ST_IGN
  } xact_st_e;
endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ena_bit,
  output logic [1:0]        speed_bits
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))
        mem[i] <= wr_data;
    end
  end

  assign rd_data    = mem[rd_addr];
  assign ena_bit    = mem[ENA_REG][ENA_BIT];
  assign speed_bits = mem[SPEED_REG][SPEED_LSB +: 2];
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso,
  output logic              wr_en,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wr_data,
  output xact_st_e          st_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              sck_q;
  logic [DATA_W-1:0] rx;
  logic [DATA_W-1:0] tx;
  logic [CNT_W-1:0]  bitcnt;
  logic [ADDR_W-1:0] addr;
  logic              is_rd;
  xact_st_e          st;

  logic              rise, fall, byte_done;
  logic [DATA_W-1:0] rx_next;

  assign rise      = sck_s & ~sck_q & ~cs_s;
  assign fall      = ~sck_s & sck_q & ~cs_s;
  assign rx_next   = {rx[DATA_W-2:0], mosi_s};
  assign byte_done = rise && (bitcnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      rx     <= '0;
      tx     <= '0;
      bitcnt <= '0;
      addr   <= '0;
      is_rd  <= 1'b0;
      st     <= ST_CMD;
    end else begin
      sck_q <= sck_s;
      if (cs_s) begin
        st     <= ST_CMD;
        bitcnt <= '0;
        tx     <= '0;
      end else begin
        if (rise) begin
          rx     <= rx_next;
          bitcnt <= bitcnt + 1'b1;
        end
        if (byte_done) begin
          unique case (st)
            ST_CMD: begin
              if (rx_next == CMD_READ) begin
                is_rd <= 1'b1;
                st    <= ST_ADDR;
              end else if (rx_next == CMD_WRITE) begin
                is_rd <= 1'b0;
                st    <= ST_ADDR;
              end else begin
                st <= ST_IGN;
              end
            end
            ST_ADDR: begin
              addr <= rx_next[ADDR_W-1:0];
              st   <= is_rd ? ST_RD : ST_WR;
            end
            ST_RD, ST_WR: addr <= addr + 1'b1;
            default: ;
          endcase
        end
        if (fall && st == ST_RD)
          tx <= (bitcnt == '0) ? rd_data : (tx << 1);
      end
    end
  end

  assign miso    = tx[DATA_W-1];
  assign wr_en   = byte_done && (st == ST_WR);
  assign wr_data = rx_next;
  assign addr_o  = addr;
  assign st_o    = st;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic       sw_enable,
  output logic [1:0] spi_speed
);
  logic              sck_s, cs_s, mosi_s;
  logic              wr_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  xact_st_e          st;

  spi_reg_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b010)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sck, cs_n, mosi}),
    .q     ({sck_s, cs_s, mosi_s})
  );

  spi_reg_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_s   (sck_s),
    .cs_s    (cs_s),
    .mosi_s  (mosi_s),
    .rd_data (rd_data),
    .miso    (miso),
    .wr_en   (wr_en),
    .addr_o  (addr),
    .wr_data (wr_data),
    .st_o    (st)
  );

  spi_reg_file #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (addr),
    .wr_data    (wr_data),
    .rd_addr    (addr),
    .rd_data    (rd_data),
    .ena_bit    (sw_enable),
    .speed_bits (spi_speed)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input xact_st_e          st,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_bit0,
  input logic              miso,
  input logic              sw_enable
);
  AST_WRITE_STEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> addr == ADDR_W'($past(addr) + 1'b1)); // R5

  AST_CS_HIGH_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> st == ST_CMD); // R6

  AST_NO_WRITE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !wr_en); // R7

  AST_SINGLE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R3

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_RD) |-> !miso); // R8

  AST_ENABLE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(ENA_REG)) |=> sw_enable == $past(wr_bit0)); // R9
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_s      (cs_s),
  .st        (st),
  .wr_en     (wr_en),
  .addr      (addr),
  .wr_bit0   (wr_data[0]),
  .miso      (miso),
  .sw_enable (sw_enable)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb_top;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic       miso;
  logic       sw_enable;
  logic [1:0] spi_speed;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  unstable;

  always #2.5 clk = ~clk;

  spi_reg_slave dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (sck),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .miso      (miso),
    .sw_enable (sw_enable),
    .spi_speed (spi_speed)
  );

  // {address byte, data byte}: write then read back at address & 0x7F
  localparam logic [15:0] VEC [6] = '{
    16'h05A5, 16'h7F3C, 16'h40FF, 16'h0001, 16'h8A5A, 16'h3366
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] t, input int nbits, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = t[i];
      wait_clk(HALF);
      r[i] = miso;
      sck = 1'b1;
      wait_clk(HALF / 2);
      if (miso !== r[i]) unstable = 1'b1;
      wait_clk(HALF / 2);
      if (miso !== r[i]) unstable = 1'b1;
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] r);
    xfer_bits(t, 8, r);
  endtask

  task automatic open_cs();
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic close_cs();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r;
    open_cs();
    xfer(8'h02, r);
    xfer(a, r);
    xfer(d, r);
    close_cs();
  endtask

  task automatic rd1(input logic [7:0] a, output logic [7:0] d);
    logic [7:0] r;
    open_cs();
    xfer(8'h03, r);
    xfer(a, r);
    xfer(8'h00, d);
    close_cs();
  endtask

  initial begin
    logic [7:0] r, r0, r1, r2;
    logic [7:0] b [5];
    unstable = 1'b0;
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(4);

    // R11: reset state at the ports
    chk({7'd0, miso}, 8'h00, "R11 miso");
    chk({7'd0, sw_enable}, 8'h00, "R11 sw_enable");
    chk({6'd0, spi_speed}, 8'h00, "R10 R11 spi_speed");
    rd1(8'h14, r);
    chk(r, 8'h00, "R11 register after reset");

    // R2 R3 R4: table-driven single writes and reads
    for (int i = 0; i < 6; i++) begin
      wr1(VEC[i][15:8], VEC[i][7:0]);
      rd1({1'b0, VEC[i][14:8]}, r);
      chk(r, VEC[i][7:0], "R2 R3 R4 write/read back");
    end

    // R5: burst write across the top address, then burst read
    open_cs();
    xfer(8'h02, r); xfer(8'h7E, r);
    xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); xfer(8'h44, r);
    close_cs();
    open_cs();
    xfer(8'h03, r); xfer(8'h7E, r);
    for (int i = 0; i < 5; i++) xfer(8'h00, b[i]);
    close_cs();
    chk(b[0], 8'h11, "R5 burst reg 126");
    chk(b[1], 8'h22, "R5 burst reg 127");
    chk(b[2], 8'h33, "R5 wrap reg 0");
    chk(b[3], 8'h44, "R5 wrap reg 1");
    chk(b[4], 8'h00, "R5 wrap reg 2");
    chk({7'd0, sw_enable}, 8'h00, "R9 enable low for 0x44");

    // R9: enable bit
    wr1(8'h01, 8'h03);
    chk({7'd0, sw_enable}, 8'h01, "R9 enable set");
    wr1(8'h01, 8'h02);
    chk({7'd0, sw_enable}, 8'h00, "R9 enable cleared");

    // R10: speed field
    wr1(8'h0C, 8'h20);
    chk({6'd0, spi_speed}, 8'h02, "R10 speed 10");
    wr1(8'h0C, 8'hDF);
    chk({6'd0, spi_speed}, 8'h01, "R10 speed 01");

    // R8: unknown command is inert
    open_cs();
    xfer(8'h07, r0); xfer(8'h05, r1); xfer(8'h99, r2);
    close_cs();
    chk(r0 | r1 | r2, 8'h00, "R8 miso low");
    rd1(8'h05, r);
    chk(r, 8'hA5, "R8 register unchanged");

    // R7: partial data byte dropped
    open_cs();
    xfer(8'h02, r); xfer(8'h30, r);
    xfer_bits(8'hF0, 4, r);
    close_cs();
    rd1(8'h30, r);
    chk(r, 8'h00, "R7 partial byte dropped");

    // R6: chip-select high ends a burst, next byte is a command
    open_cs();
    xfer(8'h02, r); xfer(8'h31, r); xfer(8'h77, r);
    close_cs();
    open_cs();
    xfer(8'h03, r); xfer(8'h31, r); xfer(8'h00, r0); xfer(8'h00, r1);
    close_cs();
    chk(r0, 8'h77, "R6 new command after cs cycle");
    chk(r1, 8'h00, "R6 next address in fresh burst");

    // R1: MISO never moved while SCK was high
    chk({7'd0, unstable}, 8'h00, "R1 miso stable in high phase");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule